// File: doc/BRIEF.md
# Power Mode Clock Controller

This block decides, for each of four operating modes, which clock enables are allowed through: the fast oscillator, the slow oscillator, the CPU, the wake-up timer and the watchdog. It also produces the system clock enable by dividing the active CPU source by a power of two. The oscillators enter as single-cycle tick pulses sampled on the controller clock, so every output is a clock enable rather than a gated clock.

The CPU moves between modes by presenting a mode code with a request strobe while it runs. Entering one of the two sleep modes records the run mode that was active. A wake event, such as a pin change or a wake-up timer interrupt, brings the block back to that recorded mode. A change of divide select is held back until the current divided period ends, so the divided enable never shows a shortened period.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode is FAST (code 0), the CPU enable is 1 and the divide ratio is 1, so `sys_en` follows `fast_tick`.
- R2: In FAST (code 0), `fast_en` follows `fast_tick`, `slow_en` follows `slow_tick` and `cpu_en` is 1. The fast-off control has no effect in this mode.
- R3: In SLOW (code 1), `slow_en` follows `slow_tick` and `cpu_en` is 1. `fast_en` follows `fast_tick` while `fast_off` is 0 and stays 0 while `fast_off` is 1. The divider counts `slow_tick` only.
- R4: In IDLE (code 2), `fast_en`, `cpu_en` and `sys_en` are 0, `slow_en` follows `slow_tick`, and `wkt_run` is 1.
- R5: In STOP (code 3), `fast_en`, `slow_en`, `cpu_en`, `sys_en` and `wkt_run` are all 0.
- R6: `wdt_run` is 1 in FAST, SLOW and IDLE. In STOP it equals `wdt_keep`.
- R7: With `div_sel` = k, `sys_en` pulses on every 2^k-th tick of the CPU source, starting on the first tick after the ratio takes effect.
- R8: A new `div_sel` value is adopted only on a tick that produces a `sys_en` pulse. Pulses before that tick keep the old spacing.
- R9: In IDLE or STOP, `wake` high at a clock edge returns the mode to the run mode (FAST or SLOW) that was active when the sleep mode was entered.
- R10: `wake` has no effect in FAST or SLOW, and `req_valid` has no effect in IDLE or STOP.
- R11: In FAST or SLOW, `req_valid` high at a clock edge sets the mode to `req_mode` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | One-cycle tick from the fast oscillator |
| slow_tick | input | 1 | One-cycle tick from the slow oscillator |
| req_valid | input | 1 | Mode request strobe from the CPU |
| req_mode | input | 2 | Requested mode: 0 FAST, 1 SLOW, 2 IDLE, 3 STOP |
| fast_off | input | 1 | Turns the fast clock off while in SLOW |
| wdt_keep | input | 1 | Lets the watchdog run in STOP |
| div_sel | input | DIV_W | Divide select; ratio is 2^div_sel |
| wake | input | 1 | Wake event from pin change or wake-up timer |
| fast_en | output | 1 | Gated fast clock enable |
| slow_en | output | 1 | Gated slow clock enable |
| cpu_en | output | 1 | CPU running |
| sys_en | output | 1 | Divided system clock enable |
| mode_o | output | 2 | Current mode code |
| wkt_run | output | 1 | Wake-up timer may run |
| wdt_run | output | 1 | Watchdog may run |

## Verification
The assertions check the per-mode gating on every cycle: the quiet outputs in STOP and IDLE, the fast-off gate in SLOW, the watchdog permission outside STOP, that `sys_en` never fires without a source tick, and that a run mode holds without a request while a sleep mode leaves on wake. Only the bench scenarios can show the exact spacing of divided pulses for each select, that a select change waits for the old boundary, and that wake returns to the particular run mode recorded at entry.

// File: rtl/pmcc_pkg.sv
package pmcc_pkg;
   typedef enum logic [1:0] {
      PM_FAST = 2'd0,
      PM_SLOW = 2'd1,
      PM_IDLE = 2'd2,
      PM_STOP = 2'd3
   } pm_mode_e;

   function automatic logic pm_is_sleep(input pm_mode_e m);
      return (m == PM_IDLE) || (m == PM_STOP);
   endfunction
endpackage

// File: rtl/pmcc_mode_fsm.sv
module pmcc_mode_fsm
   import pmcc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_mode,
   input  logic       wake,
   output pm_mode_e   mode_q
);
   pm_mode_e ret_q;
   pm_mode_e req_e;

   assign req_e = pm_mode_e'(req_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_FAST;
         ret_q  <= PM_FAST;
      end else begin
         unique case (mode_q)
            PM_FAST, PM_SLOW: begin
               if (req_valid) begin
                  mode_q <= req_e;
                  if (pm_is_sleep(req_e))
                     ret_q <= mode_q;
               end
            end
            default: begin
               if (wake)
                  mode_q <= ret_q;
            end
         endcase
      end
   end
endmodule

// File: rtl/pmcc_gate.sv
module pmcc_gate
   import pmcc_pkg::*;
(
   input  pm_mode_e mode,
   input  logic     fast_tick,
   input  logic     slow_tick,
   input  logic     fast_off,
   input  logic     wdt_keep,
   output logic     fast_en,
   output logic     slow_en,
   output logic     cpu_run,
   output logic     src_tick,
   output logic     wkt_run,
   output logic     wdt_run
);
   logic fast_on;
   logic slow_on;

   always_comb begin
      fast_on  = 1'b0;
      slow_on  = 1'b1;
      cpu_run  = 1'b0;
      src_tick = 1'b0;
      unique case (mode)
         PM_FAST: begin
            fast_on  = 1'b1;
            cpu_run  = 1'b1;
            src_tick = fast_tick;
         end
         PM_SLOW: begin
            fast_on  = !fast_off;
            cpu_run  = 1'b1;
            src_tick = slow_tick;
         end
         PM_IDLE: begin
            fast_on  = 1'b0;
         end
         default: begin
            slow_on  = 1'b0;
         end
      endcase
   end

   assign fast_en = fast_tick & fast_on;
   assign slow_en = slow_tick & slow_on;
   assign wkt_run = slow_on;
   assign wdt_run = slow_on | wdt_keep;
endmodule

// File: rtl/pmcc_prescaler.sv
module pmcc_prescaler #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic [DIV_W-1:0] sel,
   output logic             tick_o
);
   localparam int NSEL  = 1 << DIV_W;
   localparam int CNT_W = (NSEL > 1) ? NSEL - 1 : 1;

   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_width
      $error("pmcc_prescaler: DIV_W must lie in 1..4");
   end

   logic [CNT_W-1:0] lim_tab [NSEL];
   logic [DIV_W-1:0] act_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   for (genvar i = 0; i < NSEL; i++) begin : g_lim
      assign lim_tab[i] = CNT_W'((64'd1 << i) - 64'd1);
   end

   assign hit    = (cnt_q == lim_tab[act_q]);
   assign tick_o = src_tick & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else if (src_tick) begin
         if (hit) begin
            cnt_q <= '0;
            act_q <= sel;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
   import pmcc_pkg::*;
#(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_tick,
   input  logic             slow_tick,
   input  logic             req_valid,
   input  logic [1:0]       req_mode,
   input  logic             fast_off,
   input  logic             wdt_keep,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             wake,
   output logic             fast_en,
   output logic             slow_en,
   output logic             cpu_en,
   output logic             sys_en,
   output logic [1:0]       mode_o,
   output logic             wkt_run,
   output logic             wdt_run
);
   pm_mode_e mode;
   logic     src_tick;

   pmcc_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_mode  (req_mode),
      .wake      (wake),
      .mode_q    (mode)
   );

   pmcc_gate u_gate (
      .mode      (mode),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .fast_off  (fast_off),
      .wdt_keep  (wdt_keep),
      .fast_en   (fast_en),
      .slow_en   (slow_en),
      .cpu_run   (cpu_en),
      .src_tick  (src_tick),
      .wkt_run   (wkt_run),
      .wdt_run   (wdt_run)
   );

   pmcc_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .sel      (div_sel),
      .tick_o   (sys_en)
   );

   assign mode_o = mode;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fast_tick,
   input logic       slow_tick,
   input logic       req_valid,
   input logic       fast_off,
   input logic       wdt_keep,
   input logic       wake,
   input logic       fast_en,
   input logic       slow_en,
   input logic       cpu_en,
   input logic       sys_en,
   input logic [1:0] mode_o,
   input logic       wkt_run,
   input logic       wdt_run
);
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |-> (!fast_en && !slow_en && !cpu_en && !sys_en && !wkt_run)); // R5
   AST_STOP_WDT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |-> (wdt_run == wdt_keep)); // R6
   AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd2) |-> (!fast_en && !cpu_en && !sys_en && wkt_run && (slow_en == slow_tick))); // R4
   AST_SLOW_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd1 && fast_off) |-> !fast_en); // R3
   AST_WDT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd3) |-> wdt_run); // R6
   AST_SYS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      sys_en |-> (fast_tick || slow_tick)); // R7
   AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_o[1] && !req_valid) |=> $stable(mode_o)); // R10
   AST_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[1] && wake) |=> (!mode_o[1] && cpu_en)); // R9
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (.*);

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   // fields: [10:9] mode, [8] fast_off, [7] wdt_keep, [6] fast_tick, [5] slow_tick,
   //         [4] fast_en, [3] slow_en, [2] cpu_en, [1] wkt_run, [0] wdt_run
   localparam logic [10:0] VEC [NVEC] = '{
      11'b00_0_0_11_11111,
      11'b00_1_0_10_10111,
      11'b01_0_0_11_11111,
      11'b01_1_0_11_01111,
      11'b01_1_0_01_01111,
      11'b10_0_0_11_01011,
      11'b10_0_0_00_00011,
      11'b11_0_0_11_00000,
      11'b11_0_1_11_00001,
      11'b00_0_1_01_01111
   };

   logic clk = 0, rst_n = 0;
   logic fast_tick = 0, slow_tick = 0, req_valid = 0, fast_off = 0, wdt_keep = 0, wake = 0;
   logic [1:0] req_mode = 0, div_sel = 0, mode_o;
   logic fast_en, slow_en, cpu_en, sys_en, wkt_run, wdt_run;
   int n_run = 0, n_fail = 0;
   logic [31:0] pm;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_clk_ctrl #(.DIV_W(2)) u0 (.*);

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic go_mode(input logic [1:0] m);
      if (mode_o[1]) begin
         wake = 1;
         @(negedge clk);
         wake = 0;
      end
      if (mode_o != m) begin
         req_mode = m; req_valid = 1;
         @(negedge clk);
         req_valid = 0;
      end
   endtask

   task automatic run_ticks(input int n, input logic ft, input logic st, output logic [31:0] m);
      m = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fast_tick = ft; slow_tick = st;
         #1 m[i] = sys_en;
      end
      @(negedge clk);
      fast_tick = 0; slow_tick = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(mode_o == 2'd0, "R1 mode", mode_o, 0);
      check(cpu_en, "R1 cpu_en", cpu_en, 1);
      fast_tick = 1; #1;
      check(sys_en, "R1 ratio one", sys_en, 1);
      @(negedge clk); fast_tick = 0;

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         logic [10:0] e;
         string tg;
         e = VEC[v];
         @(negedge clk);
         go_mode(e[10:9]);
         fast_off = e[8]; wdt_keep = e[7]; fast_tick = e[6]; slow_tick = e[5];
         #1;
         case (e[10:9])
            2'd0: tg = "R2";
            2'd1: tg = "R3";
            2'd2: tg = "R4";
            default: tg = "R5";
         endcase
         check(mode_o == e[10:9], "R11 mode entered", mode_o, e[10:9]);
         check({fast_en, slow_en, cpu_en, wkt_run} == e[4:1], tg,
               {fast_en, slow_en, cpu_en, wkt_run}, e[4:1]);
         check(wdt_run == e[0], "R6 wdt_run", wdt_run, e[0]);
         if (e[10]) check(!sys_en, "R4 R5 sys_en quiet", sys_en, 0);
         @(negedge clk);
         fast_tick = 0; slow_tick = 0; fast_off = 0; wdt_keep = 0;
      end

      // divider
      go_mode(2'd0);
      div_sel = 2'd2;
      run_ticks(12, 1, 0, pm);
      check(pm[11:0] == 12'h111, "R7 divide by 4", pm[11:0], 12'h111);
      div_sel = 2'd3;
      run_ticks(17, 1, 0, pm);
      check(pm[16:0] == 17'h10101, "R7 divide by 8", pm[16:0], 17'h10101);
      run_ticks(4, 1, 0, pm);
      check(pm[3:0] == 4'h0, "R8 mid period", pm[3:0], 0);
      div_sel = 2'd0;
      run_ticks(6, 1, 0, pm);
      check(pm[5:0] == 6'h38, "R8 waits for boundary", pm[5:0], 6'h38);
      go_mode(2'd1);
      div_sel = 2'd1;
      run_ticks(4, 1, 0, pm);
      check(pm[3:0] == 4'h0, "R3 fast tick not counted in SLOW", pm[3:0], 0);
      run_ticks(6, 0, 1, pm);
      check(pm[5:0] == 6'h15, "R7 divide by 2 on slow", pm[5:0], 6'h15);

      // wake and ignore rules
      go_mode(2'd0);
      go_mode(2'd2);
      check(mode_o == 2'd2, "R11 enter IDLE", mode_o, 2);
      wake = 1; @(negedge clk); wake = 0;
      check(mode_o == 2'd0, "R9 IDLE returns FAST", mode_o, 0);
      go_mode(2'd1);
      go_mode(2'd3);
      req_mode = 2'd0; req_valid = 1; @(negedge clk); req_valid = 0;
      check(mode_o == 2'd3, "R10 request ignored in STOP", mode_o, 3);
      wake = 1; @(negedge clk); wake = 0;
      check(mode_o == 2'd1, "R9 STOP returns SLOW", mode_o, 1);
      wake = 1; @(negedge clk); wake = 0;
      check(mode_o == 2'd1, "R10 wake ignored in SLOW", mode_o, 1);
      go_mode(2'd0);
      wake = 1; @(negedge clk); wake = 0;
      check(mode_o == 2'd0, "R10 wake ignored in FAST", mode_o, 0);

      finish_run();
   end
endmodule